// File: doc/BRIEF.md
# LCD Drive Level Encoder

This block converts the scan state of a multiplexed LCD panel into per-pin drive level codes. The panel has 16 common (row) electrodes and 64 segment (column) electrodes. The block takes the active row index, a frame-type flag, the 64-bit data word for that row, a blanking input and a static-off override. Every clock it produces one registered 2-bit code per electrode, and each code names one of four bias rails. An analog stage outside the block turns the codes into voltages.

Drive polarity alternates between two frame types, so the average voltage across every pixel is zero. In a frame of type A the selected row is pulled to the top rail and lit columns to ground. A frame of type B mirrors this. Blanking darkens every column but leaves the row scan running. The static-off override parks all electrodes at the low bias rail, whatever the other inputs are.

Top module: `lcd_level_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, every common code and every segment code becomes 2'b01 after that edge.
- R2: Codes are 2'b00 = ground, 2'b01 = low bias rail, 2'b10 = high bias rail, 2'b11 = top rail. Common k uses bits [2k+1:2k] of `com_lvl`. Segment i uses bits [2i+1:2i] of `seg_lvl` and is driven from `row_data[i]`.
- R3: While `force_off` is high, every common and every segment code is 2'b01, whatever the values of `blank`, `frame_b`, `row_idx` and `row_data`.
- R4: While `force_off` is low, exactly one common is at a select level (2'b00 or 2'b11), and it is the common numbered `row_idx`.
- R5: In frame A (`frame_b` = 0) the selected common is 2'b11 and all other commons are 2'b01.
- R6: In frame B (`frame_b` = 1) the selected common is 2'b00 and all other commons are 2'b10.
- R7: In frame A without blanking, a segment whose data bit is 1 is 2'b00, and a segment whose data bit is 0 is 2'b10.
- R8: In frame B without blanking, a segment whose data bit is 1 is 2'b11, and a segment whose data bit is 0 is 2'b01.
- R9: With `blank` high and `force_off` low, every segment takes the off code of the current frame (2'b10 in A, 2'b01 in B), whatever `row_data` holds. The commons keep scanning as in R5 and R6.
- R10: The outputs are registered. They reflect the inputs sampled at a rising clock edge, change only just after an edge, and hold between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_idx | input | 4 | Index of the row being scanned |
| frame_b | input | 1 | Frame type: 0 = A, 1 = B |
| row_data | input | 64 | Display bits of the active row, bit i feeds segment i |
| blank | input | 1 | Darken all segments |
| force_off | input | 1 | Static display-off override |
| com_lvl | output | 32 | Two-bit level code per common electrode |
| seg_lvl | output | 128 | Two-bit level code per segment electrode |

## Verification
The only state in the block is its output registers, so any wrong internal level choice appears at the ports one clock after the inputs that cause it. A wrong polarity choice shows as a common or segment code from the wrong rail pair in the very next cycle. A bad row decode shows as zero or two select-level commons. A leak through blanking or through the override shows as a lit segment code while it should be dark. Because nothing is stored beyond one register stage, each error is visible within a single cycle and never hides for longer.

// File: rtl/lcdlvl_pkg.sv
package lcdlvl_pkg;

    // Two-bit rail selection code driven per electrode.
    typedef enum logic [1:0] {
        LVL_GND     = 2'b00,
        LVL_BIAS_LO = 2'b01,
        LVL_BIAS_HI = 2'b10,
        LVL_RAIL    = 2'b11
    } drv_lvl_e;

    // Rail choice for each electrode role in the current cycle.
    typedef struct packed {
        drv_lvl_e com_sel;
        drv_lvl_e com_idle;
        drv_lvl_e seg_on;
        drv_lvl_e seg_off;
    } lvl_set_t;

    localparam logic [1:0] STATIC_OFF_CODE = LVL_BIAS_LO;

    localparam lvl_set_t SET_STATIC_OFF = '{
        com_sel:  LVL_BIAS_LO,
        com_idle: LVL_BIAS_LO,
        seg_on:   LVL_BIAS_LO,
        seg_off:  LVL_BIAS_LO
    };

    localparam lvl_set_t SET_FRAME_A = '{
        com_sel:  LVL_RAIL,
        com_idle: LVL_BIAS_LO,
        seg_on:   LVL_GND,
        seg_off:  LVL_BIAS_HI
    };

    localparam lvl_set_t SET_FRAME_B = '{
        com_sel:  LVL_GND,
        com_idle: LVL_BIAS_HI,
        seg_on:   LVL_RAIL,
        seg_off:  LVL_BIAS_LO
    };

    // Pick the rail set for the current mode; blanking folds the lit
    // segment level onto the dark one of the same frame.
    function automatic lvl_set_t pick_levels(input logic frame_b,
                                             input logic blank,
                                             input logic force_off);
        lvl_set_t s;
        if (force_off) begin
            s = SET_STATIC_OFF;
        end else begin
            s = frame_b ? SET_FRAME_B : SET_FRAME_A;
            if (blank) begin
                s.seg_on = s.seg_off;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/lcd_lvl_select.sv
module lcd_lvl_select
    import lcdlvl_pkg::*;
(
    input  logic     frame_b,
    input  logic     blank,
    input  logic     force_off,
    output lvl_set_t lvl_set
);

    always_comb begin
        lvl_set = pick_levels(frame_b, blank, force_off);
    end

endmodule

// File: rtl/lcd_com_encoder.sv
module lcd_com_encoder
    import lcdlvl_pkg::*;
#(
    parameter int N_COM = 16,
    localparam int ROW_W = $clog2(N_COM)
) (
    input  logic [ROW_W-1:0]   row_idx,
    input  lvl_set_t           lvl_set,
    output logic [2*N_COM-1:0] com_code
);

    for (genvar k = 0; k < N_COM; k++) begin : g_com
        always_comb begin
            if (row_idx == ROW_W'(k)) begin
                com_code[2*k +: 2] = lvl_set.com_sel;
            end else begin
                com_code[2*k +: 2] = lvl_set.com_idle;
            end
        end
    end

endmodule

// File: rtl/lcd_seg_encoder.sv
module lcd_seg_encoder
    import lcdlvl_pkg::*;
#(
    parameter int N_SEG = 64
) (
    input  logic [N_SEG-1:0]   row_data,
    input  lvl_set_t           lvl_set,
    output logic [2*N_SEG-1:0] seg_code
);

    for (genvar i = 0; i < N_SEG; i++) begin : g_seg
        always_comb begin
            if (row_data[i]) begin
                seg_code[2*i +: 2] = lvl_set.seg_on;
            end else begin
                seg_code[2*i +: 2] = lvl_set.seg_off;
            end
        end
    end

endmodule

// File: rtl/lcd_level_encoder.sv
module lcd_level_encoder
    import lcdlvl_pkg::*;
#(
    parameter int N_COM = 16,
    parameter int N_SEG = 64,
    localparam int ROW_W = $clog2(N_COM)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ROW_W-1:0]   row_idx,
    input  logic               frame_b,
    input  logic [N_SEG-1:0]   row_data,
    input  logic               blank,
    input  logic               force_off,
    output logic [2*N_COM-1:0] com_lvl,
    output logic [2*N_SEG-1:0] seg_lvl
);

    lvl_set_t           lvl_set;
    logic [2*N_COM-1:0] com_next;
    logic [2*N_SEG-1:0] seg_next;

    lcd_lvl_select u_select (
        .frame_b   (frame_b),
        .blank     (blank),
        .force_off (force_off),
        .lvl_set   (lvl_set)
    );

    lcd_com_encoder #(.N_COM(N_COM)) u_com (
        .row_idx  (row_idx),
        .lvl_set  (lvl_set),
        .com_code (com_next)
    );

    lcd_seg_encoder #(.N_SEG(N_SEG)) u_seg (
        .row_data (row_data),
        .lvl_set  (lvl_set),
        .seg_code (seg_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            com_lvl <= {N_COM{STATIC_OFF_CODE}};
            seg_lvl <= {N_SEG{STATIC_OFF_CODE}};
        end else begin
            com_lvl <= com_next;
            seg_lvl <= seg_next;
        end
    end

endmodule

// File: rtl/lcd_level_encoder_chk.sv
module lcd_level_encoder_chk #(
    parameter int N_COM = 16,
    parameter int N_SEG = 64,
    localparam int ROW_W = $clog2(N_COM)
) (
    input logic               clk,
    input logic               rst,
    input logic [ROW_W-1:0]   row_idx,
    input logic               frame_b,
    input logic               blank,
    input logic               force_off,
    input logic [2*N_COM-1:0] com_lvl,
    input logic [2*N_SEG-1:0] seg_lvl
);

    logic [ROW_W-1:0] row_q;
    logic [1:0]       sel_code;
    int               n_com_sel, n_com_00, n_com_01, n_com_10, n_com_11;
    int               n_seg_lit, n_seg_01, n_seg_11;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else begin
            row_q <= row_idx;
        end
    end

    always_comb begin
        n_com_sel = 0; n_com_00 = 0; n_com_01 = 0; n_com_10 = 0; n_com_11 = 0;
        sel_code  = 2'b01;
        for (int k = 0; k < N_COM; k++) begin
            case (com_lvl[2*k +: 2])
                2'b00:   n_com_00 = n_com_00 + 1;
                2'b01:   n_com_01 = n_com_01 + 1;
                2'b10:   n_com_10 = n_com_10 + 1;
                default: n_com_11 = n_com_11 + 1;
            endcase
            if (row_q == ROW_W'(k)) begin
                sel_code = com_lvl[2*k +: 2];
            end
        end
        n_com_sel = n_com_00 + n_com_11;
    end

    always_comb begin
        n_seg_lit = 0; n_seg_01 = 0; n_seg_11 = 0;
        for (int i = 0; i < N_SEG; i++) begin
            if (seg_lvl[2*i +: 2] == 2'b00 || seg_lvl[2*i +: 2] == 2'b11) begin
                n_seg_lit = n_seg_lit + 1;
            end
            if (seg_lvl[2*i +: 2] == 2'b01) n_seg_01 = n_seg_01 + 1;
            if (seg_lvl[2*i +: 2] == 2'b11) n_seg_11 = n_seg_11 + 1;
        end
    end

    AST_STATIC_OFF: assert property (@(posedge clk) disable iff (rst)
        force_off |=> (n_com_01 == N_COM && n_seg_01 == N_SEG)); // R3

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
        !force_off |=> (n_com_sel == 1)); // R4

    AST_ROW_SELECTED: assert property (@(posedge clk) disable iff (rst)
        !force_off |=> (sel_code == 2'b00 || sel_code == 2'b11)); // R4

    AST_FRAME_A_COM: assert property (@(posedge clk) disable iff (rst)
        (!force_off && !frame_b) |=> (n_com_11 == 1 && n_com_01 == N_COM - 1)); // R5

    AST_FRAME_B_COM: assert property (@(posedge clk) disable iff (rst)
        (!force_off && frame_b) |=> (n_com_00 == 1 && n_com_10 == N_COM - 1)); // R6

    AST_SEG_RAILS_A: assert property (@(posedge clk) disable iff (rst)
        (!force_off && !frame_b) |=> (n_seg_01 == 0 && n_seg_11 == 0)); // R7

    AST_SEG_RAILS_B: assert property (@(posedge clk) disable iff (rst)
        (!force_off && frame_b) |=> (n_seg_lit == n_seg_11)); // R8

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
        (blank && !force_off) |=> (n_seg_lit == 0)); // R9

endmodule

bind lcd_level_encoder lcd_level_encoder_chk #(
    .N_COM (N_COM),
    .N_SEG (N_SEG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .row_idx   (row_idx),
    .frame_b   (frame_b),
    .blank     (blank),
    .force_off (force_off),
    .com_lvl   (com_lvl),
    .seg_lvl   (seg_lvl)
);

// File: tb/test_lcd_level_encoder.sv
`timescale 1ns/1ps
module test_lcd_level_encoder;

    localparam int NC = 16;
    localparam int NS = 64;
    localparam int WATCHDOG_CYCLES = 200000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [3:0]      row_idx = '0;
    logic            frame_b = 1'b0;
    logic [NS-1:0]   row_data = '0;
    logic            blank = 1'b0;
    logic            force_off = 1'b0;
    logic [2*NC-1:0] com_lvl;
    logic [2*NS-1:0] seg_lvl;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    lcd_level_encoder i_lcd_level_encoder (
        .clk       (clk),
        .rst       (rst),
        .row_idx   (row_idx),
        .frame_b   (frame_b),
        .row_data  (row_data),
        .blank     (blank),
        .force_off (force_off),
        .com_lvl   (com_lvl),
        .seg_lvl   (seg_lvl)
    );

    task automatic check(input string req, input logic [2*NS-1:0] act,
                         input logic [2*NS-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of the requirements: expected commons and segments.
    function automatic logic [2*NC-1:0] exp_com(input logic [3:0] r, input logic fb,
                                                input logic fo);
        logic [2*NC-1:0] v;
        for (int k = 0; k < NC; k++) begin
            if (fo)           v[2*k +: 2] = 2'b01;
            else if (k == r)  v[2*k +: 2] = fb ? 2'b00 : 2'b11;
            else              v[2*k +: 2] = fb ? 2'b10 : 2'b01;
        end
        return v;
    endfunction

    function automatic logic [2*NS-1:0] exp_seg(input logic [NS-1:0] d, input logic fb,
                                                input logic bl, input logic fo);
        logic [2*NS-1:0] v;
        for (int i = 0; i < NS; i++) begin
            if (fo)                v[2*i +: 2] = 2'b01;
            else if (d[i] && !bl)  v[2*i +: 2] = fb ? 2'b11 : 2'b00;
            else                   v[2*i +: 2] = fb ? 2'b01 : 2'b10;
        end
        return v;
    endfunction

    task automatic apply(input logic [3:0] r, input logic fb, input logic [NS-1:0] d,
                         input logic bl, input logic fo);
        @(negedge clk);
        row_idx = r; frame_b = fb; row_data = d; blank = bl; force_off = fo;
        @(posedge clk);
        #1;
    endtask

    task automatic apply_check(input string req, input logic [3:0] r, input logic fb,
                               input logic [NS-1:0] d, input logic bl, input logic fo);
        apply(r, fb, d, bl, fo);
        check({req, " commons"}, {{(2*NS-2*NC){1'b0}}, com_lvl},
              {{(2*NS-2*NC){1'b0}}, exp_com(r, fb, fo)});
        check({req, " segments"}, seg_lvl, exp_seg(d, fb, bl, fo));
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1; row_idx = 4'd5; frame_b = 1'b0; row_data = '1;
        blank = 1'b0; force_off = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        // R1: reset parks everything at the low bias rail
        check("R1 commons", {{(2*NS-2*NC){1'b0}}, com_lvl},
              {{(2*NS-2*NC){1'b0}}, {NC{2'b01}}});
        check("R1 segments", seg_lvl, {NS{2'b01}});
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_encoding;
        // R2: lane positions; row 3 in frame A, data bits 0 and 63 set
        apply(4'd3, 1'b0, {1'b1, {(NS-2){1'b0}}, 1'b1}, 1'b0, 1'b0);
        check("R2 seg0", {126'b0, seg_lvl[1:0]}, {126'b0, 2'b00});
        check("R2 seg63", {126'b0, seg_lvl[127:126]}, {126'b0, 2'b00});
        check("R2 seg1", {126'b0, seg_lvl[3:2]}, {126'b0, 2'b10});
        check("R2 com3", {126'b0, com_lvl[7:6]}, {126'b0, 2'b11});
    endtask

    task automatic t_frame_a;
        apply_check("R5 R7 frameA row0", 4'd0, 1'b0, 64'hA5A5_0F0F_FFFF_0001, 1'b0, 1'b0);
        apply_check("R5 R7 frameA row9", 4'd9, 1'b0, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0);
    endtask

    task automatic t_frame_b;
        apply_check("R6 R8 frameB row15", 4'd15, 1'b1, 64'h5555_AAAA_5555_AAAA, 1'b0, 1'b0);
        apply_check("R6 R8 frameB row7", 4'd7, 1'b1, 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b0);
    endtask

    task automatic t_row_walk;
        for (int r = 0; r < NC; r++) begin
            apply_check("R4 row walk", 4'(r), r[0], {4{16'h1 << r}}, 1'b0, 1'b0);
        end
    endtask

    task automatic t_blank;
        apply_check("R9 blank frameA", 4'd4, 1'b0, '1, 1'b1, 1'b0);
        apply_check("R9 blank frameB", 4'd11, 1'b1, '1, 1'b1, 1'b0);
        apply_check("R9 blank release", 4'd11, 1'b1, 64'hF0F0_F0F0_F0F0_F0F0, 1'b0, 1'b0);
    endtask

    task automatic t_force_off;
        apply_check("R3 force frameA", 4'd2, 1'b0, '1, 1'b0, 1'b1);
        apply_check("R3 force frameB blank", 4'd13, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b1);
        apply_check("R3 force release", 4'd13, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0);
    endtask

    task automatic t_timing;
        logic [2*NS-1:0] seg_old;
        logic [2*NC-1:0] com_old;
        apply(4'd6, 1'b0, 64'h00FF_00FF_00FF_00FF, 1'b0, 1'b0);
        seg_old = seg_lvl;
        com_old = com_lvl;
        // change inputs mid-cycle; outputs must hold until the next edge
        #1;
        row_idx = 4'd8; frame_b = 1'b1; row_data = '0;
        #1;
        check("R10 hold segments", seg_lvl, seg_old);
        check("R10 hold commons", {{(2*NS-2*NC){1'b0}}, com_lvl},
              {{(2*NS-2*NC){1'b0}}, com_old});
        @(posedge clk);
        #1;
        check("R10 update segments", seg_lvl, exp_seg('0, 1'b1, 1'b0, 1'b0));
        check("R10 update commons", {{(2*NS-2*NC){1'b0}}, com_lvl},
              {{(2*NS-2*NC){1'b0}}, exp_com(4'd8, 1'b1, 1'b0)});
    endtask

    initial begin
        t_reset();
        t_encoding();
        t_frame_a();
        t_frame_b();
        t_row_walk();
        t_blank();
        t_force_off();
        t_timing();
        t_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule